// File: doc/BRIEF.md
# Vectored Interrupt Controller with Bus Acknowledge

This block gathers eight internal event lines from a serial controller into one active-low interrupt request for a host processor on an asynchronous bus. Software reads the raw event levels through a status register, picks which events may raise the request through a mask register, and programs an 8-bit vector. Every bus transfer is closed by an active-low data-transfer acknowledge driven by the block.

When the processor runs an interrupt-acknowledge cycle while an unmasked event is active, the block places the vector on the data bus and acknowledges. With nothing pending it stays silent for the whole cycle, so another device on the bus can answer. Five of the events can also be sent, active low, to five dedicated output pins; a route register turns each pin on or off.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask register reads 0x00, the vector register reads the parameter `VEC_RESET` (default 0x0F), the route register reads 0x00, `irq_n` is 1, `dtack_n` is 1, `dout_en` is 0 and all `route_pin` bits are 1.
- R2: A read of the status register returns the current level of every event input, bit k for event k, whatever the mask holds.
- R3: `irq_n` is 0 in the clock after any event k is active while mask bit k is 1, and 1 in the clock after no active event has its mask bit set.
- R4: When `iack_n` is sampled low while an unmasked event is active, from the next clock `dout` carries the vector register, `dout_en` is 1 and `dtack_n` is 0, held until `iack_n` returns high.
- R5: When `iack_n` is sampled low with no unmasked event active, `dtack_n` stays 1 and `dout_en` stays 0 for the whole acknowledge cycle.
- R6: With `cs_n` sampled low, `rw`=0 writes `din` to the selected register once at the first clock of the access, and `rw`=1 drives that register on `dout` with `dout_en` 1; in both cases `dtack_n` is 0 from the next clock until `cs_n` returns high. Later changes of `din` within the same access have no effect.
- R7: Register select values: 0x2 status (read only), 0x5 mask, 0xC vector, 0xD route (bits 4:0, upper bits read 0). Every other select value reads 0x00 and a write to it changes no register.
- R8: `dtack_n` returns to 1 and `dout_en` to 0 in the first clock after both `cs_n` and `iack_n` are sampled high.
- R9: With route bit k set, `route_pin[k]` is 0 while its source event is active and 1 otherwise; with the bit clear the pin is 1. Sources of pins 0 to 4 are events 3, 0, 4, 1, 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select for register access |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 4 | Register select |
| iack_n | input | 1 | Active-low interrupt-acknowledge cycle |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data or vector to the bus |
| dout_en | output | 1 | 1 while the block drives the data bus |
| dtack_n | output | 1 | Active-low transfer acknowledge |
| events | input | 8 | Internal event levels, bit k = event k |
| irq_n | output | 1 | Active-low interrupt request |
| route_pin | output | 5 | Event signals steered to output pins, active low |

## Verification
The assertions assume that all bus inputs are already synchronous to `clk`, that `cs_n` and `iack_n` are never low together, and that `rw`, `rsel` and `din` are stable from the clock where an access starts. The bench keeps to this by changing inputs only on the falling edge, running one access at a time, and always letting the block see both strobes high for at least one clock before the next cycle starts. The one exception is a deliberate change of `din` in the middle of a write, which tests that the first value is the one stored.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int SEL_W = 4;

   localparam logic [SEL_W-1:0] SEL_STATUS = 4'h2;
   localparam logic [SEL_W-1:0] SEL_MASK   = 4'h5;
   localparam logic [SEL_W-1:0] SEL_VECTOR = 4'hC;
   localparam logic [SEL_W-1:0] SEL_ROUTE  = 4'hD;

   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_ACK  = 2'd1,
      BUS_SKIP = 2'd2
   } bus_state_e;
endpackage

// File: rtl/irqv_bus_ctrl.sv
module irqv_bus_ctrl
   import irqv_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rw,
   input  logic              iack_n,
   input  logic              pending,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] vector,
   output logic              wr_stb,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              dtack_n
);
   bus_state_e        state_q;
   logic [DATA_W-1:0] dout_q;
   logic              drive_q;

   assign wr_stb  = (state_q == BUS_IDLE) && iack_n && !cs_n && !rw;
   assign dout    = dout_q;
   assign dout_en = drive_q;
   assign dtack_n = (state_q != BUS_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BUS_IDLE;
         dout_q  <= '0;
         drive_q <= 1'b0;
      end else begin
         case (state_q)
            BUS_IDLE: begin
               if (!iack_n) begin
                  if (pending) begin
                     state_q <= BUS_ACK;
                     dout_q  <= vector;
                     drive_q <= 1'b1;
                  end else begin
                     state_q <= BUS_SKIP;
                  end
               end else if (!cs_n) begin
                  state_q <= BUS_ACK;
                  if (rw) begin
                     dout_q  <= rd_data;
                     drive_q <= 1'b1;
                  end
               end
            end
            BUS_ACK: begin
               if (cs_n && iack_n) begin
                  state_q <= BUS_IDLE;
                  drive_q <= 1'b0;
               end
            end
            BUS_SKIP: begin
               if (iack_n) state_q <= BUS_IDLE;
            end
            default: begin
               state_q <= BUS_IDLE;
               drive_q <= 1'b0;
            end
         endcase
      end
   end

   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && iack_n) |=> (dtack_n && !dout_en)); // R8
   AST_DRIVE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> !dtack_n); // R6
   AST_IACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BUS_IDLE && !iack_n && !pending) |=> (dtack_n && !dout_en)); // R5
   AST_IACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BUS_IDLE && !iack_n && pending) |=> (!dtack_n && dout_en && dout == $past(vector))); // R4
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
   import irqv_pkg::*;
#(
   parameter int               DATA_W    = 8,
   parameter int               EVT_W     = 8,
   parameter int               PIN_W     = 5,
   parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [SEL_W-1:0]  rsel,
   input  logic [DATA_W-1:0] din,
   input  logic [EVT_W-1:0]  events,
   output logic [EVT_W-1:0]  mask,
   output logic [PIN_W-1:0]  route_cfg,
   output logic [DATA_W-1:0] vector,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PAD_W = DATA_W - PIN_W;

   if (EVT_W != DATA_W) begin : g_chk_evt
      $error("irqv_regs: EVT_W must equal DATA_W");
   end
   if (PIN_W > DATA_W || PIN_W < 1) begin : g_chk_pin
      $error("irqv_regs: PIN_W out of range");
   end

   logic wr_mask, wr_vec, wr_route;

   assign wr_mask  = wr_stb && (rsel == SEL_MASK);
   assign wr_vec   = wr_stb && (rsel == SEL_VECTOR);
   assign wr_route = wr_stb && (rsel == SEL_ROUTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask      <= '0;
         vector    <= VEC_RESET;
         route_cfg <= '0;
      end else begin
         if (wr_mask)  mask      <= din;
         if (wr_vec)   vector    <= din;
         if (wr_route) route_cfg <= din[PIN_W-1:0];
      end
   end

   always_comb begin
      case (rsel)
         SEL_STATUS: rd_data = events;
         SEL_MASK:   rd_data = mask;
         SEL_VECTOR: rd_data = vector;
         SEL_ROUTE:  rd_data = {{PAD_W{1'b0}}, route_cfg};
         default:    rd_data = '0;
      endcase
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_mask, wr_vec, wr_route})); // R7
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(mask)); // R6
   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(vector)); // R6
endmodule

// File: rtl/irqv_core.sv
module irqv_core #(
   parameter int EVT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] events,
   input  logic [EVT_W-1:0] mask,
   output logic             pending,
   output logic             irq_n
);
   if (EVT_W < 1) begin : g_chk_w
      $error("irqv_core: EVT_W must be positive");
   end

   assign pending = |(events & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= !pending;
   end

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      ((events & mask) != '0) |=> !irq_n); // R3
   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ((events & mask) == '0) |=> irq_n); // R3
endmodule

// File: rtl/irqv_route.sv
module irqv_route #(
   parameter int                       EVT_W     = 8,
   parameter int                       PIN_W     = 5,
   parameter int                       SRC_W     = $clog2(EVT_W),
   parameter logic [PIN_W*SRC_W-1:0]   ROUTE_MAP = {3'd5, 3'd1, 3'd4, 3'd0, 3'd3}
) (
   input  logic [EVT_W-1:0] events,
   input  logic [PIN_W-1:0] route_cfg,
   output logic [PIN_W-1:0] route_pin
);
   for (genvar k = 0; k < PIN_W; k++) begin : g_pin
      localparam int SRC = int'(ROUTE_MAP[k*SRC_W +: SRC_W]);
      if (SRC >= EVT_W) begin : g_chk_src
         $error("irqv_route: map entry beyond event count");
      end
      assign route_pin[k] = route_cfg[k] ? !events[SRC] : 1'b1;
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                EVT_W     = 8,
   parameter int                PIN_W     = 5,
   parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rw,
   input  logic [SEL_W-1:0]  rsel,
   input  logic              iack_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              dtack_n,
   input  logic [EVT_W-1:0]  events,
   output logic              irq_n,
   output logic [PIN_W-1:0]  route_pin
);
   logic [EVT_W-1:0]  mask;
   logic [PIN_W-1:0]  route_cfg;
   logic [DATA_W-1:0] vector;
   logic [DATA_W-1:0] rd_data;
   logic              wr_stb;
   logic              pending;

   irqv_regs #(
      .DATA_W(DATA_W), .EVT_W(EVT_W), .PIN_W(PIN_W), .VEC_RESET(VEC_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rsel(rsel), .din(din),
      .events(events), .mask(mask), .route_cfg(route_cfg), .vector(vector),
      .rd_data(rd_data)
   );

   irqv_core #(.EVT_W(EVT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .events(events), .mask(mask),
      .pending(pending), .irq_n(irq_n)
   );

   irqv_bus_ctrl #(.DATA_W(DATA_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .iack_n(iack_n),
      .pending(pending), .rd_data(rd_data), .vector(vector), .wr_stb(wr_stb),
      .dout(dout), .dout_en(dout_en), .dtack_n(dtack_n)
   );

   irqv_route #(.EVT_W(EVT_W), .PIN_W(PIN_W)) u_route (
      .events(events), .route_cfg(route_cfg), .route_pin(route_pin)
   );
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rw = 1'b1, iack_n = 1'b1;
   logic [3:0] rsel = '0;
   logic [7:0] din = '0, events = '0;
   logic [7:0] dout;
   logic       dout_en, dtack_n, irq_n;
   logic [4:0] route_pin;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_vector_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .rsel(rsel),
      .iack_n(iack_n), .din(din), .dout(dout), .dout_en(dout_en),
      .dtack_n(dtack_n), .events(events), .irq_n(irq_n), .route_pin(route_pin)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); cs_n = 1'b0; rw = 1'b0; rsel = a; din = d;
      @(negedge clk); chk("R6 write ack", {7'd0, dtack_n}, 8'd0);
      cs_n = 1'b1;
      @(negedge clk); chk("R8 write release", {6'd0, dtack_n, dout_en}, 8'h02);
   endtask

   task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); cs_n = 1'b0; rw = 1'b1; rsel = a;
      @(negedge clk); chk(req, dout, exp);
      chk("R6 read ack/drive", {6'd0, dtack_n, dout_en}, 8'h01);
      cs_n = 1'b1;
      @(negedge clk); chk("R8 read release", {6'd0, dtack_n, dout_en}, 8'h02);
   endtask

   task automatic t_reset();
      chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
      chk("R1 dtack/dout_en", {6'd0, dtack_n, dout_en}, 8'h02);
      chk("R1 route pins", {3'd0, route_pin}, 8'h1F);
      bus_read(4'h5, 8'h00, "R1 mask reset");
      bus_read(4'hC, 8'h0F, "R1 vector reset");
      bus_read(4'hD, 8'h00, "R1 route reset");
   endtask

   task automatic t_status();
      @(negedge clk); events = 8'hA5;
      bus_read(4'h2, 8'hA5, "R2 status with mask clear");
      chk("R3 masked events no irq", {7'd0, irq_n}, 8'h01);
      bus_write(4'h5, 8'h01);
      bus_read(4'h2, 8'hA5, "R2 status with mask set");
      bus_write(4'h5, 8'h00);
      @(negedge clk); events = 8'h00;
   endtask

   task automatic t_mask();
      bus_write(4'h5, 8'h04);
      @(negedge clk); events = 8'h04;
      @(negedge clk); chk("R3 unmasked event raises irq", {7'd0, irq_n}, 8'h00);
      events = 8'h01;
      @(negedge clk); chk("R3 masked-only event drops irq", {7'd0, irq_n}, 8'h01);
      events = 8'h00;
   endtask

   task automatic t_iack_pending();
      bus_write(4'hC, 8'h42);
      @(negedge clk); events = 8'h04;
      @(negedge clk); iack_n = 1'b0;
      @(negedge clk); chk("R4 vector on bus", dout, 8'h42);
      chk("R4 ack and drive", {6'd0, dtack_n, dout_en}, 8'h01);
      @(negedge clk); chk("R4 held", {6'd0, dtack_n, dout_en}, 8'h01);
      iack_n = 1'b1;
      @(negedge clk); chk("R8 iack release", {6'd0, dtack_n, dout_en}, 8'h02);
      events = 8'h00;
   endtask

   task automatic t_iack_idle();
      @(negedge clk); events = 8'h08;
      @(negedge clk); iack_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); chk("R5 silent iack", {6'd0, dtack_n, dout_en}, 8'h02);
      end
      iack_n = 1'b1;
      @(negedge clk); chk("R5 silent after iack", {6'd0, dtack_n, dout_en}, 8'h02);
      events = 8'h00;
   endtask

   task automatic t_decode();
      bus_write(4'h7, 8'hFF);
      bus_read(4'h7, 8'h00, "R7 unused select reads zero");
      bus_read(4'h5, 8'h04, "R7 unused write leaves mask");
      bus_read(4'hC, 8'h42, "R7 unused write leaves vector");
      bus_write(4'hD, 8'hFF);
      bus_read(4'hD, 8'h1F, "R7 route upper bits zero");
      bus_write(4'hD, 8'h00);
   endtask

   task automatic t_single_write();
      @(negedge clk); cs_n = 1'b0; rw = 1'b0; rsel = 4'hC; din = 8'h5A;
      @(negedge clk); din = 8'h99;
      @(negedge clk); chk("R6 ack held during long write", {7'd0, dtack_n}, 8'h00);
      cs_n = 1'b1;
      @(negedge clk);
      bus_read(4'hC, 8'h5A, "R6 single latch per access");
   endtask

   task automatic t_route();
      bus_write(4'hD, 8'h1F);
      @(negedge clk); events = 8'h3B;
      #1 chk("R9 routed pins", {3'd0, route_pin}, 8'h00);
      events = 8'h01;
      #1 chk("R9 only event0 on pin1", {3'd0, route_pin}, 8'h1D);
      bus_write(4'hD, 8'h05);
      events = 8'h3B;
      #1 chk("R9 route bits gate pins", {3'd0, route_pin}, 8'h1A);
      events = 8'h00;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_status();
      t_mask();
      t_iack_pending();
      t_iack_idle();
      t_decode();
      t_single_write();
      t_route();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule